// File: doc/BRIEF.md
# Zero-Cross Gain Update Gate

This block sits between the gain-control logic of an audio input path and the amplifier gain setting. It holds a requested gain value until the audio waveform passes through zero, and only then copies it to the active gain output. Changing the gain at a zero crossing avoids audible clicks. A programmable timeout caps the wait, so that a signal sitting on one side of zero, such as a DC offset or silence, cannot hold back a gain change for ever.

Gain requests come from three sources: a host register write, a recovery step from an automatic level controller, and a limiter step from the same controller. Host and recovery requests always wait for a crossing or for the timeout. Limiter steps wait in the same way by default. A mode input lets them bypass the wait and take effect on the next clock, so that a sudden overload is attenuated at once. The block does not detect levels or size the steps; it only decides when a value is committed.

Top module: `zc_gain_gate`

## Requirements
- R1: After synchronous reset, `gain_out` is 0, `commit_pulse` is 0, and no request is pending. A crossing or timeout seen straight after reset commits nothing.
- R2: The 2-bit `tmo_sel` sets the timeout in `fs_tick` periods. The codes 0, 1, 2 and 3 select 128, 256, 512 and 1024. Once a request is pending, the first tick is the one that arrives on an edge after the request was captured. The pending value commits on the clock edge after the edge that counts the last tick of the selected limit.
- R3: A zero crossing is a valid sample that is exactly zero, or whose sign bit (the MSB) differs from the sign bit of the previous valid sample. A pending value commits on the clock edge that sees the crossing sample. The first valid sample after reset counts only if it is zero.
- R4: Host and recovery requests always wait for a crossing or a timeout. If both arrive in the same cycle, the host value is kept.
- R5: When `lim_direct` is 0, a limiter request is gated like the other two sources and has the lowest priority among them. When `lim_direct` is 1, a limiter request commits `lim_gain` on the next edge. Any pending request and its timeout count are left untouched. If a gated commit falls due in that same cycle, it is deferred.
- R6: A request that arrives while another is pending replaces the pending value but does not restart the timeout count.
- R7: `commit_pulse` is high for exactly one cycle per commit, and `gain_out` takes its new value in that same cycle. `gain_out` never changes while `commit_pulse` is low.
- R8: With nothing pending, zero crossings and elapsed ticks cause no commit and no change of `gain_out`.
- R9: A sample presented with `smp_valid` low is ignored. It neither triggers a commit nor becomes the reference sign for the next valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | SAMPLE_W | Signed audio sample, two's complement |
| smp_valid | input | 1 | Sample strobe |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| host_req | input | 1 | Host gain write request |
| host_gain | input | GAIN_W | Host requested gain |
| rcv_req | input | 1 | Recovery step request |
| rcv_gain | input | GAIN_W | Recovery step gain |
| lim_req | input | 1 | Limiter step request |
| lim_gain | input | GAIN_W | Limiter step gain |
| lim_direct | input | 1 | 1: limiter steps bypass zero-cross gating |
| tmo_sel | input | 2 | Timeout select code |
| gain_out | output | GAIN_W | Committed gain |
| commit_pulse | output | 1 | One-cycle strobe when gain_out is updated |

## Verification
A request driven in cycle n becomes pending at the edge that closes cycle n. A crossing sample driven in a later cycle m shows up as `commit_pulse` and the new `gain_out` right after the edge that closes cycle m. A direct limiter request is likewise seen one edge after it is driven. A timeout commit appears one edge after the edge that counts the final tick. The bench drives inputs and samples outputs on falling edges, and counts edges from each stimulus to exactly these points. It also checks that no commit appears one edge early and that the pulse is gone one edge later.

// File: rtl/zc_pkg.sv
package zc_pkg;

    localparam int TMO_BASE_LOG = 7;                       // code 0 -> 2^7 ticks
    localparam int TMO_MAX      = 1 << (TMO_BASE_LOG + 3); // code 3 -> 1024 ticks
    localparam int TMO_CNT_W    = $clog2(TMO_MAX + 1);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HOST = 2'd1,
        SRC_RCV  = 2'd2,
        SRC_LIM  = 2'd3
    } req_src_e;

    // number of sample ticks allowed before a forced commit
    function automatic logic [TMO_CNT_W-1:0] tmo_limit(input logic [1:0] code);
        logic [TMO_CNT_W-1:0] base;
        base = TMO_CNT_W'(1) << TMO_BASE_LOG;
        return base << code;
    endfunction

endpackage

// File: rtl/zc_sign_track.sv
module zc_sign_track #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    output logic                xing
);
    localparam int MSB = SAMPLE_W - 1;

    logic prev_sign;
    logic have_prev;
    logic is_zero;

    assign is_zero = (smp_data == '0);
    assign xing    = smp_valid && (is_zero || (have_prev && (smp_data[MSB] != prev_sign)));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sign <= 1'b0;
            have_prev <= 1'b0;
        end else if (smp_valid) begin
            prev_sign <= smp_data[MSB];
            have_prev <= 1'b1;
        end
    end

    // R9: an invalid sample never moves the sign reference
    p_sign_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(prev_sign) && $stable(have_prev));

endmodule

// File: rtl/zc_tmo_timer.sv
module zc_tmo_timer
    import zc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       clear,
    input  logic       active,
    input  logic       fs_tick,
    input  logic [1:0] tmo_sel,
    output logic       expired
);
    logic [TMO_CNT_W-1:0] cnt;
    logic [TMO_CNT_W-1:0] limit;

    assign limit   = tmo_limit(tmo_sel);
    assign expired = active && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || clear) begin
            cnt <= '0;
        end else if (active && fs_tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the count never runs past the largest timeout
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= TMO_CNT_W'(TMO_MAX));

    // R8: the counter stays at zero while idle
    p_idle_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        (!active && !restart) |=> (cnt == '0));

endmodule

// File: rtl/zc_req_merge.sv
module zc_req_merge
    import zc_pkg::*;
#(
    parameter int GAIN_W = 8
) (
    input  logic              host_req,
    input  logic [GAIN_W-1:0] host_gain,
    input  logic              rcv_req,
    input  logic [GAIN_W-1:0] rcv_gain,
    input  logic              lim_req,
    input  logic [GAIN_W-1:0] lim_gain,
    input  logic              lim_direct,
    output req_src_e          gated_src,
    output logic [GAIN_W-1:0] gated_gain,
    output logic              direct_fire,
    output logic [GAIN_W-1:0] direct_gain
);
    always_comb begin
        gated_src  = SRC_NONE;
        gated_gain = '0;
        if (host_req) begin
            gated_src  = SRC_HOST;
            gated_gain = host_gain;
        end else if (rcv_req) begin
            gated_src  = SRC_RCV;
            gated_gain = rcv_gain;
        end else if (lim_req && !lim_direct) begin
            gated_src  = SRC_LIM;
            gated_gain = lim_gain;
        end
    end

    assign direct_fire = lim_req && lim_direct;
    assign direct_gain = lim_gain;

endmodule

// File: rtl/zc_gain_gate.sv
module zc_gain_gate
    import zc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    input  logic                fs_tick,
    input  logic                host_req,
    input  logic [GAIN_W-1:0]   host_gain,
    input  logic                rcv_req,
    input  logic [GAIN_W-1:0]   rcv_gain,
    input  logic                lim_req,
    input  logic [GAIN_W-1:0]   lim_gain,
    input  logic                lim_direct,
    input  logic [1:0]          tmo_sel,
    output logic [GAIN_W-1:0]   gain_out,
    output logic                commit_pulse
);
    typedef struct packed {
        logic              valid;
        req_src_e          src;
        logic [GAIN_W-1:0] gain;
    } pend_t;

    pend_t             pend_q;
    req_src_e          gated_src;
    logic [GAIN_W-1:0] gated_gain;
    logic              direct_fire;
    logic [GAIN_W-1:0] direct_gain;
    logic              xing;
    logic              expired;
    logic              gated_commit;
    logic              new_req;
    logic              restart;

    zc_req_merge #(.GAIN_W(GAIN_W)) u_merge (
        .host_req    (host_req),
        .host_gain   (host_gain),
        .rcv_req     (rcv_req),
        .rcv_gain    (rcv_gain),
        .lim_req     (lim_req),
        .lim_gain    (lim_gain),
        .lim_direct  (lim_direct),
        .gated_src   (gated_src),
        .gated_gain  (gated_gain),
        .direct_fire (direct_fire),
        .direct_gain (direct_gain)
    );

    zc_sign_track #(.SAMPLE_W(SAMPLE_W)) u_sign (
        .clk       (clk),
        .rst       (rst),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .xing      (xing)
    );

    assign new_req      = (gated_src != SRC_NONE);
    assign gated_commit = pend_q.valid && (xing || expired) && !direct_fire;
    assign restart      = new_req && (!pend_q.valid || gated_commit);

    zc_tmo_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .clear   (gated_commit),
        .active  (pend_q.valid),
        .fs_tick (fs_tick),
        .tmo_sel (tmo_sel),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '{valid: 1'b0, src: SRC_NONE, gain: '0};
        end else if (new_req) begin
            pend_q <= '{valid: 1'b1, src: gated_src, gain: gated_gain};
        end else if (gated_commit) begin
            pend_q.valid <= 1'b0;
            pend_q.src   <= SRC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_out     <= '0;
            commit_pulse <= 1'b0;
        end else if (direct_fire) begin
            gain_out     <= direct_gain;
            commit_pulse <= 1'b1;
        end else if (gated_commit) begin
            gain_out     <= pend_q.gain;
            commit_pulse <= 1'b1;
        end else begin
            commit_pulse <= 1'b0;
        end
    end

    // R5: a bypassing limiter step lands on the next edge
    p_direct_r5: assert property (@(posedge clk) disable iff (rst)
        direct_fire |=> (commit_pulse && gain_out == $past(lim_gain)));

    // R8: with nothing waiting, no commit can follow
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!pend_q.valid && !(lim_req && lim_direct)) |=> !commit_pulse);

    // R7: the output only moves together with the strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !commit_pulse |-> $stable(gain_out));

    // R6: a pending entry is never dropped without a commit
    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q.valid && !xing && !expired) |=> pend_q.valid);

endmodule

// File: tb/sim_zc_gain_gate.sv
module sim_zc_gain_gate;
    localparam int SW = 16;
    localparam int GW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [SW-1:0] smp_data;
    logic          smp_valid;
    logic          fs_tick;
    logic          host_req;
    logic [GW-1:0] host_gain;
    logic          rcv_req;
    logic [GW-1:0] rcv_gain;
    logic          lim_req;
    logic [GW-1:0] lim_gain;
    logic          lim_direct;
    logic [1:0]    tmo_sel;
    logic [GW-1:0] gain_out;
    logic          commit_pulse;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    zc_gain_gate #(.SAMPLE_W(SW), .GAIN_W(GW)) u0 (
        .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
        .fs_tick(fs_tick), .host_req(host_req), .host_gain(host_gain),
        .rcv_req(rcv_req), .rcv_gain(rcv_gain), .lim_req(lim_req),
        .lim_gain(lim_gain), .lim_direct(lim_direct), .tmo_sel(tmo_sel),
        .gain_out(gain_out), .commit_pulse(commit_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        smp_valid = 1'b0; smp_data = '0; fs_tick = 1'b0;
        host_req = 1'b0; rcv_req = 1'b0; lim_req = 1'b0;
    endtask

    task automatic smp(input int v);
        @(negedge clk);
        idle_inputs();
        smp_valid = 1'b1;
        smp_data  = SW'(v);
    endtask

    task automatic req_host(input int g);
        @(negedge clk);
        idle_inputs();
        host_req = 1'b1; host_gain = GW'(g);
    endtask

    task automatic quiet();
        @(negedge clk);
        idle_inputs();
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1;
        idle_inputs();
        lim_direct = 1'b0; tmo_sel = 2'd0;
        host_gain = '0; rcv_gain = '0; lim_gain = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 gain after reset", int'(gain_out), 0);
        chk("R1 pulse after reset", int'(commit_pulse), 0);
        smp(0);
        quiet();
        chk("R1 no commit after reset", int'(commit_pulse), 0);
    endtask

    // R2: run the timeout for one code
    task automatic t_timeout(input int code, input int g);
        int lim;
        lim = 128 << code;
        tmo_sel = 2'(code);
        req_host(g);
        @(negedge clk);
        idle_inputs();
        fs_tick = 1'b1;
        for (int i = 0; i < lim; i++) @(negedge clk);
        chk($sformatf("R2 no early commit code %0d", code), int'(commit_pulse), 0);
        @(negedge clk);
        fs_tick = 1'b0;
        chk($sformatf("R2 timeout commit code %0d", code), int'(commit_pulse), 1);
        chk($sformatf("R2 timeout gain code %0d", code), int'(gain_out), g);
        @(negedge clk);
        chk("R7 pulse one cycle", int'(commit_pulse), 0);
    endtask

    // R3 and R7
    task automatic t_crossing();
        tmo_sel = 2'd3;
        smp(300);
        req_host(21);
        smp(-7);
        chk("R3 pending before crossing edge", int'(commit_pulse), 0);
        quiet();
        chk("R3 crossing commit", int'(commit_pulse), 1);
        chk("R3 crossing gain", int'(gain_out), 21);
        quiet();
        chk("R7 pulse drops", int'(commit_pulse), 0);
        chk("R7 gain held", int'(gain_out), 21);
    endtask

    // R9
    task automatic t_invalid();
        smp(100);
        req_host(33);
        @(negedge clk);
        idle_inputs();
        smp_valid = 1'b0; smp_data = SW'(-5);
        smp(50);
        quiet();
        chk("R9 invalid sample ignored", int'(gain_out), 21);
        smp(0);
        quiet();
        chk("R3 zero sample commit", int'(gain_out), 33);
        chk("R3 zero sample pulse", int'(commit_pulse), 1);
    endtask

    // R8
    task automatic t_idle();
        int seen;
        seen = 0;
        tmo_sel = 2'd0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            idle_inputs();
            fs_tick = 1'b1;
            smp_valid = 1'b1;
            smp_data = (i % 2 == 0) ? SW'(40) : SW'(-40);
            if (commit_pulse) seen++;
        end
        quiet();
        chk("R8 no idle commit", seen, 0);
        chk("R8 gain unchanged", int'(gain_out), 33);
    endtask

    // R6
    task automatic t_replace();
        tmo_sel = 2'd0;
        smp(10);
        req_host(50);
        @(negedge clk);
        idle_inputs();
        fs_tick = 1'b1;
        for (int i = 0; i < 100; i++) @(negedge clk);
        idle_inputs();
        rcv_req = 1'b1; rcv_gain = GW'(60);
        @(negedge clk);
        idle_inputs();
        fs_tick = 1'b1;
        for (int i = 0; i < 28; i++) @(negedge clk);
        chk("R6 not yet", int'(commit_pulse), 0);
        @(negedge clk);
        fs_tick = 1'b0;
        chk("R6 timer kept", int'(commit_pulse), 1);
        chk("R6 value replaced", int'(gain_out), 60);
    endtask

    // R4
    task automatic t_priority();
        tmo_sel = 2'd3;
        smp(10);
        @(negedge clk);
        idle_inputs();
        host_req = 1'b1; host_gain = GW'(70);
        rcv_req = 1'b1; rcv_gain = GW'(80);
        quiet();
        chk("R4 recovery gated", int'(commit_pulse), 0);
        smp(-10);
        quiet();
        chk("R4 host wins", int'(gain_out), 70);
    endtask

    // R5
    task automatic t_limiter();
        tmo_sel = 2'd3;
        lim_direct = 1'b0;
        smp(-10);
        @(negedge clk);
        idle_inputs();
        lim_req = 1'b1; lim_gain = GW'(90);
        quiet();
        chk("R5 gated limiter waits", int'(commit_pulse), 0);
        smp(10);
        quiet();
        chk("R5 gated limiter crossing", int'(gain_out), 90);
        req_host(95);
        @(negedge clk);
        idle_inputs();
        lim_direct = 1'b1; lim_req = 1'b1; lim_gain = GW'(15);
        smp_valid = 1'b1; smp_data = SW'(-3);
        @(negedge clk);
        idle_inputs();
        chk("R5 direct pulse", int'(commit_pulse), 1);
        chk("R5 direct gain", int'(gain_out), 15);
        quiet();
        chk("R5 pending deferred", int'(gain_out), 15);
        smp(8);
        quiet();
        chk("R5 pending kept", int'(gain_out), 95);
        lim_direct = 1'b0;
    endtask

    initial begin
        t_reset();
        for (int c = 0; c < 4; c++) t_timeout(c, 11 + c);
        t_crossing();
        t_invalid();
        t_idle();
        t_replace();
        t_priority();
        t_limiter();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule